// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between a shared interrupt distributor and one processor. Each cycle the distributor offers its current best candidate: a valid flag, an interrupt ID, a priority value and, for software-generated interrupts, the number of the CPU that raised it. The block decides whether the candidate is forwarded. If it is, the block drives an interrupt line to the processor.

The processor talks to the block through a small register port with four word addresses:

| Address | Register |
|---------|----------|
| 0 | control |
| 1 | priority mask |
| 2 | acknowledge |
| 3 | end-of-interrupt |

Reading the acknowledge register returns the ID being serviced and marks that ID active in the same clock edge. At that edge the block also sends a claim pulse back to the distributor, so that the distributor can move on to its next candidate. Writing the ID to the end-of-interrupt register retires it.

IDs 0..15 are software-generated. Their acknowledge value carries the source CPU next to the ID, and software must write that full value back to retire them. IDs 16..510 are device interrupts. Any other ID is treated as nothing pending.

Top module: `irq_ack_if`

## Requirements
- R1: Bit 0 of the control register (address 0) enables the block. While it is 0, `irqOut` stays low, an acknowledge read returns 1023 and nothing changes. Control and mask read back their stored values.
- R2: The priority mask (address 1, bits 7:0) resets to 0, which blocks every candidate. A candidate is forwarded only when its priority is numerically lower than the mask, so writing 0xF0 admits priorities 0x00..0xEF.
- R3: The acknowledge word (address 2) carries the ID in bits 9:0 and the source CPU in bits 12:10. The source field is filled only for IDs below 16 and is 0 for device IDs. The word is returned on `regRdData` in the cycle after the read strobe.
- R4: A candidate whose ID is above 510 is never forwarded. Acknowledging it returns 1023 and alters no active state. ID 510 itself is valid.
- R5: An acknowledge read of a forwarded candidate marks that ID active at the same edge. An active ID is not forwarded again, so two back-to-back reads against an unchanged candidate return the ID and then 1023.
- R6: A successful acknowledge raises `claimValid` for exactly one cycle, with `claimId` equal to the acknowledged ID, in the cycle after the read.
- R7: An end-of-interrupt write (address 3) with an active device ID in bits 9:0 retires that ID, so it can be forwarded and acknowledged again.
- R8: An end-of-interrupt write for a software-generated ID retires it only when bits 12:10 equal the source CPU captured at acknowledge. A mismatching write is ignored.
- R9: An end-of-interrupt write naming an ID that is not active has no effect.
- R10: After reset, `irqOut`, `claimValid` and `regRdData` are 0, control and mask are 0, and no ID is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regRdEn | input | 1 | Register read strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after `regRdEn` |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, lower value is more urgent |
| candSrc | input | 3 | Source CPU of a software-generated candidate |
| irqOut | output | 1 | Interrupt line to the processor |
| claimValid | output | 1 | One-cycle pulse: a candidate was acknowledged |
| claimId | output | 10 | ID acknowledged with `claimValid` |

## Verification
The bench builds the block with its default parameters: 10-bit IDs, 8-bit priorities, 3-bit source numbers, 16 software IDs and a top valid ID of 510. These values let the bench reach both range edges directly, at IDs 15/16 and 510/511. They also make source-field mismatches on software IDs and mask thresholds at both ends of the priority range reachable within a short sequence. The bench's distributor model is deliberately lazy: it keeps offering an already acknowledged ID, so the active-state blocking is seen at the port as a spurious 1023 and as a low interrupt line.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MASK = 2'd1,
    REG_ACK  = 2'd2,
    REG_EOI  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     ackTake;
    logic     eoiRetire;
    logic     ctrlWr;
    logic     maskWr;
    logic     rdFire;
    reg_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regRdEn,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       candQualify,
  input  logic       eoiMatch,
  output strobe_t    strb
);
  reg_sel_e sel;

  always_comb begin
    sel            = reg_sel_e'(regAddr);
    strb.rdSel     = sel;
    strb.rdFire    = regRdEn;
    strb.ackTake   = regRdEn && (sel == REG_ACK) && candQualify;
    strb.eoiRetire = regWrEn && (sel == REG_EOI) && eoiMatch;
    strb.ctrlWr    = regWrEn && (sel == REG_CTRL);
    strb.maskWr    = regWrEn && (sel == REG_MASK);
  end

  // R5: an acknowledge is never granted without a read of the acknowledge register
  a_r5_ack_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |-> (regRdEn && regAddr == 2'd2));
endmodule

// File: rtl/irq_ack_dp.sv
module irq_ack_dp
  import irq_ack_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 3,
  parameter int SGI_N  = 16,
  parameter int MAX_ID = 510
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [31:0]       regWrData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  output logic              candQualify,
  output logic              eoiMatch,
  output logic [31:0]       regRdData,
  output logic              irqOut,
  output logic              claimValid,
  output logic [ID_W-1:0]   claimId
);
  localparam int IDX_W = $clog2(MAX_ID + 1);
  localparam int ACT_N = 1 << IDX_W;
  localparam int SGI_W = $clog2(SGI_N);
  localparam logic [ID_W-1:0] SPURIOUS = {ID_W{1'b1}};
  localparam int WORD_USED = ID_W + SRC_W;

  logic              ctrlEn;
  logic [PRIO_W-1:0] prioMask;
  logic [ACT_N-1:0]  activeBits;
  logic [SRC_W-1:0]  sgiSrc [SGI_N];

  logic              candInRange, candIsSgi, candActive;
  logic [ID_W-1:0]   wrId;
  logic [SRC_W-1:0]  wrSrc;
  logic              wrInRange, wrIsSgi;
  logic [31:0]       ackWord, rdNext;
  logic              unusedWrHi;

  assign unusedWrHi = ^regWrData[31:WORD_USED];

  assign candInRange = (candId <= ID_W'(MAX_ID));
  assign candIsSgi   = (candId < ID_W'(SGI_N));
  assign candActive  = candInRange ? activeBits[candId[IDX_W-1:0]] : 1'b1;
  assign candQualify = ctrlEn && candValid && candInRange && !candActive
                       && (candPrio < prioMask);
  assign irqOut      = candQualify;

  assign wrId      = regWrData[ID_W-1:0];
  assign wrSrc     = regWrData[WORD_USED-1:ID_W];
  assign wrInRange = (wrId <= ID_W'(MAX_ID));
  assign wrIsSgi   = (wrId < ID_W'(SGI_N));
  assign eoiMatch  = wrInRange && activeBits[wrId[IDX_W-1:0]]
                     && (!wrIsSgi || (sgiSrc[wrId[SGI_W-1:0]] == wrSrc));

  always_comb begin
    ackWord = 32'(SPURIOUS);
    if (strb.ackTake)
      ackWord = 32'({(candIsSgi ? candSrc : {SRC_W{1'b0}}), candId});
    unique case (strb.rdSel)
      REG_CTRL: rdNext = {31'd0, ctrlEn};
      REG_MASK: rdNext = 32'(prioMask);
      REG_ACK:  rdNext = ackWord;
      default:  rdNext = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn     <= 1'b0;
      prioMask   <= '0;
      regRdData  <= '0;
      claimValid <= 1'b0;
      claimId    <= '0;
    end else begin
      if (strb.ctrlWr) ctrlEn   <= regWrData[0];
      if (strb.maskWr) prioMask <= regWrData[PRIO_W-1:0];
      if (strb.rdFire) regRdData <= rdNext;
      claimValid <= strb.ackTake;
      if (strb.ackTake) claimId <= candId;
    end
  end

  for (genvar g = 0; g < ACT_N; g++) begin : g_active
    always_ff @(posedge clk) begin
      if (!rstN)
        activeBits[g] <= 1'b0;
      else if (strb.ackTake && candId == ID_W'(g))
        activeBits[g] <= 1'b1;
      else if (strb.eoiRetire && wrId == ID_W'(g))
        activeBits[g] <= 1'b0;
    end
  end

  for (genvar s = 0; s < SGI_N; s++) begin : g_sgi_src
    always_ff @(posedge clk) begin
      if (!rstN)
        sgiSrc[s] <= '0;
      else if (strb.ackTake && candId == ID_W'(s))
        sgiSrc[s] <= candSrc;
    end
  end

  // R5: the acknowledged ID is active after the edge
  a_r5_ack_sets_active: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> activeBits[$past(candId[IDX_W-1:0])]);
  // R7: a retired ID is no longer active
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiRetire |=> !activeBits[$past(wrId[IDX_W-1:0])]);
  // R4 / R9: without an acknowledge or a retire, active state holds
  a_r9_active_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ackTake && !strb.eoiRetire) |=> $stable(activeBits));
  // R1: no claim while disabled
  a_r1_disabled_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> !claimValid);
  // R2: a closed mask forwards nothing
  a_r2_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (prioMask == '0) |-> !irqOut);
  // R4: the topmost index is never set
  a_r4_no_out_of_range_active: assert property (@(posedge clk) disable iff (!rstN)
    $countones(activeBits[ACT_N-1:MAX_ID+1]) == 0);
endmodule

// File: rtl/irq_ack_if.sv
module irq_ack_if
  import irq_ack_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 3,
  parameter int SGI_N  = 16,
  parameter int MAX_ID = 510
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  output logic              irqOut,
  output logic              claimValid,
  output logic [ID_W-1:0]   claimId
);
  strobe_t strb;
  logic    candQualify, eoiMatch;

  irq_ack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .candQualify(candQualify), .eoiMatch(eoiMatch),
    .strb(strb)
  );

  irq_ack_dp #(
    .ID_W(ID_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .SGI_N(SGI_N), .MAX_ID(MAX_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .candSrc(candSrc), .candQualify(candQualify), .eoiMatch(eoiMatch),
    .regRdData(regRdData), .irqOut(irqOut), .claimValid(claimValid),
    .claimId(claimId)
  );

  // R3: an acknowledge read returns either a valid ID or the spurious code
  a_r3_ack_id_range: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRdEn) && $past(regAddr) == 2'd2) |->
      (regRdData[ID_W-1:0] <= ID_W'(MAX_ID) || regRdData[ID_W-1:0] == {ID_W{1'b1}}));
  // R6: a claim lasts a single cycle unless a second read follows
  a_r6_claim_after_read: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> ($past(regRdEn) && $past(regAddr) == 2'd2));
endmodule

// File: tb/irq_ack_if_test.sv
module irq_ack_if_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regRdEn = 1'b0, regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        candValid = 1'b0;
  logic [9:0]  candId = '0;
  logic [7:0]  candPrio = '0;
  logic [2:0]  candSrc = '0;
  logic        irqOut, claimValid;
  logic [9:0]  claimId;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic rdSeen = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  irq_ack_if uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each read's result is compared the cycle after its strobe
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) check(tagQ.pop_front(), regRdData, expQ.pop_front());
  end

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic setCand(logic v, logic [9:0] id, logic [7:0] p, logic [2:0] s);
    @(negedge clk); candValid = v; candId = id; candPrio = p; candSrc = s;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 irq", irqOut, 0);
    check("R10 claim", claimValid, 0);
    check("R10 rdData", regRdData, 0);
    regRead(2'd0, 0, "R10 ctrl");
    regRead(2'd1, 0, "R2 mask reset");

    setCand(1, 10'd40, 8'h10, 0);
    check("R2 closed mask irq", irqOut, 0);
    regWrite(2'd1, 32'hF0);
    check("R1 disabled irq", irqOut, 0);
    regRead(2'd2, 1023, "R1 disabled ack");
    regWrite(2'd0, 1);
    check("R2 open mask irq", irqOut, 1);
    setCand(1, 10'd40, 8'hF0, 0);
    check("R2 prio equal mask", irqOut, 0);
    setCand(1, 10'd40, 8'hEF, 0);
    check("R2 prio below mask", irqOut, 1);

    setCand(1, 10'd600, 8'h10, 0);
    check("R4 out of range irq", irqOut, 0);
    regRead(2'd2, 1023, "R4 out of range ack");
    setCand(1, 10'd511, 8'h10, 0);
    check("R4 id 511 irq", irqOut, 0);
    setCand(1, 10'd40, 8'h10, 0);
    check("R4 no state change", irqOut, 1);

    regRead(2'd2, 40, "R3 ack device");
    check("R6 claim pulse", claimValid, 1);
    check("R6 claim id", claimId, 40);
    check("R5 active blocks irq", irqOut, 0);
    @(negedge clk);
    check("R6 claim one cycle", claimValid, 0);

    setCand(1, 10'd41, 8'h20, 0);
    @(negedge clk); regRdEn = 1'b1; regAddr = 2'd2;
    expQ.push_back(41); tagQ.push_back("R5 back-to-back first");
    @(negedge clk); expQ.push_back(1023); tagQ.push_back("R5 back-to-back second");
    @(negedge clk); regRdEn = 1'b0;

    setCand(1, 10'd40, 8'h10, 0);
    regWrite(2'd3, 99);
    check("R9 inactive eoi", irqOut, 0);
    regWrite(2'd3, 40);
    check("R7 retired irq", irqOut, 1);
    regRead(2'd2, 40, "R7 reacknowledge");

    setCand(1, 10'd3, 8'h10, 3'd5);
    regRead(2'd2, (5 << 10) | 3, "R3 ack software id");
    regWrite(2'd3, (2 << 10) | 3);
    check("R8 wrong source ignored", irqOut, 0);
    regWrite(2'd3, (5 << 10) | 3);
    check("R8 matching source retires", irqOut, 1);

    setCand(1, 10'd16, 8'h10, 3'd7);
    regRead(2'd2, 16, "R3 device source zero");

    setCand(1, 10'd510, 8'h10, 0);
    check("R4 id 510 forwarded", irqOut, 1);
    regRead(2'd2, 510, "R4 id 510 ack");

    regWrite(2'd1, 32'h20);
    setCand(1, 10'd50, 8'h20, 0);
    check("R2 mask 0x20 equal", irqOut, 0);
    setCand(1, 10'd50, 8'h1F, 0);
    check("R2 mask 0x20 below", irqOut, 1);

    regWrite(2'd0, 0);
    check("R1 disable drops irq", irqOut, 0);
    regRead(2'd0, 0, "R1 ctrl readback");
    regRead(2'd1, 32'h20, "R1 mask readback");
    regRead(2'd2, 1023, "R1 disabled ack spurious");
    @(negedge clk);
    check("R1 no claim when disabled", claimValid, 0);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule